// File: doc/BRIEF.md
# Range-Matching Translation Buffer with Reserved Block Slots

This block is a fully associative address translation buffer in which every entry covers a contiguous virtual range instead of a single page. Ordinary entries cover 4^k pages. Block entries cover any whole number of pages. A combinational lookup port takes a virtual address and an access kind. It returns hit, the translated physical address and the stored rights fields. If no entry matches, it raises an instruction-miss or a data-miss flag.

A command port accepts one command per cycle. The commands are:
- a variable-size insert;
- a two-step insert, where the address comes first and the protection word second;
- a range purge;
- a purge of all ordinary entries;
- slot-indexed insert, purge and purge-all on the reserved block slots.

The lowest `N_BLK` slots are reserved block slots. Ordinary purges never touch them. Ordinary entries are placed in a free slot if one exists; otherwise a round-robin victim is chosen among the ordinary slots.

Top module: `range_tlb`

## Requirements
- R1: A lookup with `lk_valid`=1 hits when a valid entry satisfies lo <= `lk_va` <= hi. The lowest-indexed matching slot wins. `lk_pa` = entry physical base + (`lk_va` - lo). `lk_prot` returns the entry's rights bits 29:1.
- R2: When `lk_valid`=1 and no entry matches, `lk_imiss` is raised if `lk_fetch`=1 and `lk_dmiss` otherwise. With `lk_valid`=0, neither flag and not `lk_hit` is raised.
- R3: Variable insert (opcode 1): size exponent k = `cmd_arg[3:0]`. The range starts at the page-aligned `cmd_va` (page = 4096 bytes) and spans 4096 << 2k bytes. The physical base is `cmd_pa` aligned down to that span.
- R4: Before a variable insert or a first-step insert installs its range, every ordinary entry overlapping that range is removed.
- R5: Range purge (opcode 4): n = `cmd_va[3:0]`. The range is [page-aligned `cmd_va`, start + (4096 << 2n) - 1]. Every ordinary entry overlapping it is removed; n = 0 removes a single page.
- R6: Block slots 0..`N_BLK`-1 are never cleared by ordinary purges, by purge-all or by overlap removal.
- R7: An ordinary install uses the lowest-indexed free ordinary slot. If no ordinary slot is free, it uses the round-robin slot, which then advances and wraps from `N_ENT`-1 back to `N_BLK`. A free-slot install leaves the pointer unchanged.
- R8: Purge-all (opcode 5) clears every ordinary slot, returns the round-robin pointer to `N_BLK` and cancels a pending two-step insert. Block slots survive.
- R9: First-step insert (opcode 2) records a one-page range and a page-aligned `cmd_pa`. Second step (opcode 3): if `cmd_va` lies in the pending range, the entry is installed with `cmd_prot`. Otherwise nothing is installed and status 2 (sequence error) is returned. Either way the pending state is cleared.
- R10: Protection word layout: access id in 18:1, U in 19, PL2 in 21:20, PL1 in 23:22, type in 26:24, B in 27, D in 28, T in 29. The word is stored and returned unchanged in those positions.
- R11: Block insert (opcode 6) writes slot `cmd_slot` with range [page-aligned `cmd_va`, + `cmd_arg` pages - 1], page-aligned `cmd_pa` and `cmd_prot`. Block purge (opcode 7) clears slot `cmd_slot`. Block purge-all (opcode 8) clears all block slots. A slot >= `N_BLK`, or a block insert with `cmd_arg`=0, returns status 1 (invalid) and changes nothing.
- R12: `cmd_done` pulses in the cycle after `cmd_valid`, with `cmd_status` 0 = ok. Unknown opcodes return 1. A lookup in the same cycle as a command sees the state from before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_fetch | input | 1 | Lookup is an instruction fetch |
| lk_va | input | VA_W | Lookup virtual address |
| lk_hit | output | 1 | Lookup matched an entry |
| lk_imiss | output | 1 | Fetch lookup missed |
| lk_dmiss | output | 1 | Data lookup missed |
| lk_pa | output | PA_W | Translated physical address |
| lk_prot | output | 29 (bits 29:1) | Rights fields of the matching entry |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command opcode |
| cmd_va | input | VA_W | Command virtual address |
| cmd_pa | input | PA_W | Command physical address |
| cmd_arg | input | 32 | Size exponent or block page count |
| cmd_prot | input | 29 (bits 29:1) | Protection word |
| cmd_slot | input | log2(N_ENT) | Block slot index |
| cmd_done | output | 1 | Command completed last cycle |
| cmd_status | output | 2 | Completion status |

## Verification
Damaged valid bits or range bounds appear at the lookup port immediately: the next lookup reports a false hit, a false miss, or a physical address off by the range offset. A wrong round-robin pointer or free-slot choice stays hidden until the ordinary slots are full. It then shows as the wrong translation disappearing on the next eviction, which is why the bench fills the buffer and walks the pointer through a wrap. A lost pending two-step state shows as a wrong status on the second step, one cycle after it is issued.

// File: rtl/range_tlb_pkg.sv
// Shared opcodes, status codes and the rights-field type of the range TLB.
// Assumes one command per cycle; encodings are fixed by the command port.
package range_tlb_pkg;

    typedef enum logic [3:0] {
        OP_NOP          = 4'd0,
        OP_INS_VAR      = 4'd1,
        OP_INS_ADDR     = 4'd2,
        OP_INS_PROT     = 4'd3,
        OP_PURGE        = 4'd4,
        OP_PURGE_ALL    = 4'd5,
        OP_BLK_INS      = 4'd6,
        OP_BLK_PURGE    = 4'd7,
        OP_BLK_PURGE_ALL = 4'd8
    } tlb_op_e;

    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_INVAL = 2'd1,
        ST_SEQ   = 2'd2
    } tlb_status_e;

    // Rights fields kept at the bit positions of the protection word.
    typedef logic [29:1] rights_t;

endpackage

// File: rtl/range_tlb_span.sv
// Computes the last byte address of a range from its page-aligned start and
// a page count. Assumes npages >= 1; a result beyond the address space
// saturates to all ones.
module range_tlb_span #(
    parameter int VA_W = 32,
    parameter int PG_W = 12
) (
    input  logic [VA_W-1:0] base_va,
    input  logic [31:0]     npages,
    output logic [VA_W-1:0] last_va
);
    localparam int EXT_W = VA_W + 33 + PG_W;

    logic [EXT_W-1:0] sum_ext;

    // Wide add so that large spans cannot wrap around.
    always_comb begin
        sum_ext = EXT_W'(base_va) + (EXT_W'(npages) << PG_W) - EXT_W'(1);
        last_va = (|sum_ext[EXT_W-1:VA_W]) ? '1 : sum_ext[VA_W-1:0];
    end
endmodule

// File: rtl/range_tlb_victim.sv
// Picks the slot for an ordinary install: the lowest free ordinary slot,
// else the round-robin pointer, which wraps within [N_BLK, N_ENT).
// Assumes N_ENT > N_BLK. The pointer moves only on a round-robin pick.
module range_tlb_victim #(
    parameter int N_ENT = 8,
    parameter int N_BLK = 2,
    localparam int IDX_W = $clog2(N_ENT),
    localparam int N_ORD = N_ENT - N_BLK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ORD-1:0] free_ord,
    input  logic             take,
    input  logic             rr_clear,
    output logic [IDX_W-1:0] victim
);
    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             free_any;

    // Priority search for the lowest free ordinary slot.
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int j = N_ORD - 1; j >= 0; j--) begin
            if (free_ord[j]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(j + N_BLK);
            end
        end
        victim = free_any ? free_idx : rr_q;
    end

    // Round-robin pointer: reset or purge-all returns it to the first ordinary slot.
    always_ff @(posedge clk) begin
        if (!rst_n || rr_clear) begin
            rr_q <= IDX_W'(N_BLK);
        end else if (take && !free_any) begin
            rr_q <= (rr_q == IDX_W'(N_ENT - 1)) ? IDX_W'(N_BLK) : rr_q + 1'b1;
        end
    end

    assert_rr_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rr_q >= IDX_W'(N_BLK)) && (32'(rr_q) < N_ENT));

    assert_victim_ordinary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (victim >= IDX_W'(N_BLK)));
endmodule

// File: rtl/range_tlb.sv
// Fully associative range-matching translation buffer with reserved block
// slots. Lookup is combinational from registered state; each command takes
// one cycle and reports status in the following cycle. Assumes N_ENT > N_BLK.
module range_tlb
    import range_tlb_pkg::*;
#(
    parameter int N_ENT = 8,
    parameter int N_BLK = 2,
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int PG_W  = 12,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic             lk_fetch,
    input  logic [VA_W-1:0]  lk_va,
    output logic             lk_hit,
    output logic             lk_imiss,
    output logic             lk_dmiss,
    output logic [PA_W-1:0]  lk_pa,
    output logic [29:1]      lk_prot,
    input  logic             cmd_valid,
    input  logic [3:0]       cmd_op,
    input  logic [VA_W-1:0]  cmd_va,
    input  logic [PA_W-1:0]  cmd_pa,
    input  logic [31:0]      cmd_arg,
    input  logic [29:1]      cmd_prot,
    input  logic [IDX_W-1:0] cmd_slot,
    output logic             cmd_done,
    output logic [1:0]       cmd_status
);
    localparam int N_ORD = N_ENT - N_BLK;

    logic [N_ENT-1:0] ent_v;
    logic [VA_W-1:0]  ent_lo [N_ENT];
    logic [VA_W-1:0]  ent_hi [N_ENT];
    logic [PA_W-1:0]  ent_pa [N_ENT];
    rights_t          ent_rt [N_ENT];

    logic             pend_v;
    logic [VA_W-1:0]  pend_lo, pend_hi;
    logic [PA_W-1:0]  pend_pa;

    logic [N_ENT-1:0] hit_vec, sweep_vec, v_swept;
    logic [IDX_W-1:0] sel, victim;
    logic [VA_W-1:0]  va_page, span_last;
    logic [PA_W-1:0]  pa_page, pa_aligned;
    logic [PA_W+31:0] pa_unit;
    logic [31:0]      span_pages;
    logic             sweep_en, prot_ok, take, slot_bad, rr_clear;
    tlb_status_e      nxt_status;

    assign va_page = {cmd_va[VA_W-1:PG_W], {PG_W{1'b0}}};
    assign pa_page = {cmd_pa[PA_W-1:PG_W], {PG_W{1'b0}}};

    // Per-slot range match for lookup and overlap test for ordinary sweeps.
    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        assign hit_vec[g] = ent_v[g] && (lk_va >= ent_lo[g]) && (lk_va <= ent_hi[g]);
        if (g >= N_BLK) begin : g_ord
            assign sweep_vec[g] = sweep_en && ent_v[g] &&
                                  (ent_lo[g] <= span_last) && (va_page <= ent_hi[g]);
        end else begin : g_blk
            assign sweep_vec[g] = 1'b0;
        end
    end

    assign v_swept = ent_v & ~sweep_vec;

    // Lookup: lowest matching slot supplies translation and rights.
    always_comb begin
        sel = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hit_vec[i]) sel = IDX_W'(i);
        end
        lk_hit   = lk_valid && (|hit_vec);
        lk_imiss = lk_valid && !(|hit_vec) && lk_fetch;
        lk_dmiss = lk_valid && !(|hit_vec) && !lk_fetch;
        lk_pa    = ent_pa[sel] + PA_W'(lk_va - ent_lo[sel]);
        lk_prot  = ent_rt[sel];
    end

    // Page count of the range named by the current command.
    always_comb begin
        case (cmd_op)
            OP_INS_VAR: span_pages = 32'd1 << {cmd_arg[3:0], 1'b0};
            OP_PURGE:   span_pages = 32'd1 << {cmd_va[3:0], 1'b0};
            OP_BLK_INS: span_pages = cmd_arg;
            default:    span_pages = 32'd1;
        endcase
    end

    range_tlb_span #(.VA_W(VA_W), .PG_W(PG_W)) u_span (
        .base_va (va_page),
        .npages  (span_pages),
        .last_va (span_last)
    );

    // Physical base aligned down to the variable-insert span.
    always_comb begin
        pa_unit    = (PA_W+32)'(1) << (PG_W + 32'({cmd_arg[3:0], 1'b0}));
        pa_aligned = cmd_pa & ~PA_W'(pa_unit - 1'b1);
    end

    // Command decode: sweep enable, allocation request and completion status.
    always_comb begin
        sweep_en = cmd_valid && (cmd_op == OP_INS_VAR || cmd_op == OP_INS_ADDR ||
                                 cmd_op == OP_PURGE);
        prot_ok  = pend_v && (cmd_va >= pend_lo) && (cmd_va <= pend_hi);
        take     = cmd_valid && (cmd_op == OP_INS_VAR || (cmd_op == OP_INS_PROT && prot_ok));
        rr_clear = cmd_valid && (cmd_op == OP_PURGE_ALL);
        slot_bad = 32'(cmd_slot) >= N_BLK;
        case (cmd_op)
            OP_INS_VAR, OP_INS_ADDR, OP_PURGE,
            OP_PURGE_ALL, OP_BLK_PURGE_ALL: nxt_status = ST_OK;
            OP_INS_PROT:  nxt_status = prot_ok ? ST_OK : ST_SEQ;
            OP_BLK_INS:   nxt_status = (slot_bad || cmd_arg == 32'd0) ? ST_INVAL : ST_OK;
            OP_BLK_PURGE: nxt_status = slot_bad ? ST_INVAL : ST_OK;
            default:      nxt_status = ST_INVAL;
        endcase
    end

    range_tlb_victim #(.N_ENT(N_ENT), .N_BLK(N_BLK)) u_victim (
        .clk      (clk),
        .rst_n    (rst_n),
        .free_ord (~v_swept[N_ENT-1:N_BLK]),
        .take     (take),
        .rr_clear (rr_clear),
        .victim   (victim)
    );

    // Entry array, pending two-step state and completion report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v      <= '0;
            pend_v     <= 1'b0;
            pend_lo    <= '0;
            pend_hi    <= '0;
            pend_pa    <= '0;
            cmd_done   <= 1'b0;
            cmd_status <= ST_OK;
            for (int i = 0; i < N_ENT; i++) begin
                ent_lo[i] <= '0;
                ent_hi[i] <= '0;
                ent_pa[i] <= '0;
                ent_rt[i] <= '0;
            end
        end else begin
            cmd_done <= cmd_valid;
            if (cmd_valid) begin
                cmd_status <= nxt_status;
                case (cmd_op)
                    OP_INS_VAR: begin
                        ent_v          <= v_swept;
                        ent_v[victim]  <= 1'b1;
                        ent_lo[victim] <= va_page;
                        ent_hi[victim] <= span_last;
                        ent_pa[victim] <= pa_aligned;
                        ent_rt[victim] <= cmd_prot;
                    end
                    OP_INS_ADDR: begin
                        ent_v   <= v_swept;
                        pend_v  <= 1'b1;
                        pend_lo <= va_page;
                        pend_hi <= span_last;
                        pend_pa <= pa_page;
                    end
                    OP_INS_PROT: begin
                        pend_v <= 1'b0;
                        if (prot_ok) begin
                            ent_v[victim]  <= 1'b1;
                            ent_lo[victim] <= pend_lo;
                            ent_hi[victim] <= pend_hi;
                            ent_pa[victim] <= pend_pa;
                            ent_rt[victim] <= cmd_prot;
                        end
                    end
                    OP_PURGE: ent_v <= v_swept;
                    OP_PURGE_ALL: begin
                        pend_v <= 1'b0;
                        for (int i = N_BLK; i < N_ENT; i++) ent_v[i] <= 1'b0;
                    end
                    OP_BLK_INS: begin
                        if (!slot_bad && cmd_arg != 32'd0) begin
                            ent_v[cmd_slot]  <= 1'b1;
                            ent_lo[cmd_slot] <= va_page;
                            ent_hi[cmd_slot] <= span_last;
                            ent_pa[cmd_slot] <= pa_page;
                            ent_rt[cmd_slot] <= cmd_prot;
                        end
                    end
                    OP_BLK_PURGE: if (!slot_bad) ent_v[cmd_slot] <= 1'b0;
                    OP_BLK_PURGE_ALL: for (int i = 0; i < N_BLK; i++) ent_v[i] <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    assert_blk_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_INS_VAR || cmd_op == OP_INS_ADDR || cmd_op == OP_INS_PROT ||
                       cmd_op == OP_PURGE || cmd_op == OP_PURGE_ALL))
        |=> (ent_v[N_BLK-1:0] == $past(ent_v[N_BLK-1:0])));

    assert_pall_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PURGE_ALL) |=> (ent_v[N_ENT-1:N_BLK] == '0) && !pend_v);

    assert_bad_slot_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_BLK_INS || cmd_op == OP_BLK_PURGE) && slot_bad)
        |=> (ent_v == $past(ent_v)) && (cmd_status == ST_INVAL));

    assert_orphan_prot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_INS_PROT && !pend_v) |=> (cmd_status == ST_SEQ));

    assert_miss_kinds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_imiss && lk_dmiss) && !(lk_hit && (lk_imiss || lk_dmiss)));

    assert_ord_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_INS_VAR) |=> ($countones(ent_v[N_ENT-1:N_BLK]) >= 1));
endmodule

// File: tb/tb_range_tlb.sv
module tb_range_tlb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 15;

    localparam logic [3:0] OP_VAR = 4'd1, OP_ADDR = 4'd2, OP_PROT = 4'd3, OP_PURGE = 4'd4,
                           OP_PALL = 4'd5, OP_BINS = 4'd6, OP_BPUR = 4'd7, OP_BPALL = 4'd8;
    localparam logic [1:0] S_OK = 2'd0, S_INV = 2'd1, S_SEQ = 2'd2;

    typedef struct packed {
        logic [23:0] tag;
        logic [3:0]  op;
        logic [31:0] va;
        logic [31:0] pa;
        logic [31:0] arg;
        logic [2:0]  slot;
        logic [1:0]  st;
        logic [31:0] lva;
        logic        lf;
        logic        lhit;
        logic [31:0] lpa;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{"R3 ", OP_VAR,   32'h0040_0000, 32'h1234_5678, 32'd1, 3'd0, S_OK,  32'h0040_2ABC, 1'b0, 1'b1, 32'h1234_6ABC},
        '{"R1 ", OP_VAR,   32'h0080_0000, 32'h0A00_0000, 32'd0, 3'd0, S_OK,  32'h0080_1000, 1'b0, 1'b0, 32'h0},
        '{"R5 ", OP_PURGE, 32'h0040_0002, 32'h0,         32'd0, 3'd0, S_OK,  32'h0040_0000, 1'b1, 1'b0, 32'h0},
        '{"R5 ", OP_PURGE, 32'h0080_1000, 32'h0,         32'd0, 3'd0, S_OK,  32'h0080_0FFF, 1'b0, 1'b1, 32'h0A00_0FFF},
        '{"R11", OP_BINS,  32'h1000_0000, 32'h2000_0000, 32'd3, 3'd1, S_OK,  32'h1000_2FFF, 1'b0, 1'b1, 32'h2000_2FFF},
        '{"R8 ", OP_PALL,  32'h0,         32'h0,         32'd0, 3'd0, S_OK,  32'h0080_0000, 1'b0, 1'b0, 32'h0},
        '{"R6 ", OP_PURGE, 32'h1000_0000, 32'h0,         32'd0, 3'd0, S_OK,  32'h1000_0010, 1'b0, 1'b1, 32'h2000_0010},
        '{"R11", OP_BINS,  32'h3000_0000, 32'h4000_0000, 32'd1, 3'd2, S_INV, 32'h3000_0000, 1'b0, 1'b0, 32'h0},
        '{"R11", OP_BPUR,  32'h0,         32'h0,         32'd0, 3'd1, S_OK,  32'h1000_0010, 1'b1, 1'b0, 32'h0},
        '{"R9 ", OP_ADDR,  32'h5000_0000, 32'h6000_0000, 32'd0, 3'd0, S_OK,  32'h5000_0000, 1'b0, 1'b0, 32'h0},
        '{"R9 ", OP_PROT,  32'h5000_0123, 32'h0,         32'd0, 3'd0, S_OK,  32'h5000_0FFF, 1'b0, 1'b1, 32'h6000_0FFF},
        '{"R9 ", OP_ADDR,  32'h5100_0000, 32'h6100_0000, 32'd0, 3'd0, S_OK,  32'h5100_0000, 1'b0, 1'b0, 32'h0},
        '{"R9 ", OP_PROT,  32'h5100_1000, 32'h0,         32'd0, 3'd0, S_SEQ, 32'h5100_0000, 1'b0, 1'b0, 32'h0},
        '{"R12", 4'hF,     32'h0,         32'h0,         32'd0, 3'd0, S_INV, 32'h5000_0000, 1'b0, 1'b1, 32'h6000_0000},
        '{"R11", OP_BINS,  32'h1000_0000, 32'h2000_0000, 32'd0, 3'd0, S_INV, 32'h1000_0000, 1'b0, 1'b0, 32'h0}
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        lk_valid = 1'b0, lk_fetch = 1'b0;
    logic [31:0] lk_va = '0;
    logic        lk_hit, lk_imiss, lk_dmiss;
    logic [31:0] lk_pa;
    logic [29:1] lk_prot;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [31:0] cmd_va = '0, cmd_pa = '0, cmd_arg = '0;
    logic [29:1] cmd_prot = '0;
    logic [2:0]  cmd_slot = '0;
    logic        cmd_done;
    logic [1:0]  cmd_status;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    range_tlb dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_fetch(lk_fetch), .lk_va(lk_va),
        .lk_hit(lk_hit), .lk_imiss(lk_imiss), .lk_dmiss(lk_dmiss), .lk_pa(lk_pa), .lk_prot(lk_prot),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_va(cmd_va), .cmd_pa(cmd_pa), .cmd_arg(cmd_arg),
        .cmd_prot(cmd_prot), .cmd_slot(cmd_slot), .cmd_done(cmd_done), .cmd_status(cmd_status)
    );

    task automatic check(input logic [23:0] req, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_valid = 1'b0; lk_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Issue one command, wait one edge, check completion status.
    task automatic do_cmd(input logic [3:0] op, input logic [31:0] va, input logic [31:0] pa,
                          input logic [31:0] arg, input logic [29:1] prot, input logic [2:0] slot,
                          input logic [1:0] st, input logic [23:0] req);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_va = va; cmd_pa = pa;
        cmd_arg = arg; cmd_prot = prot; cmd_slot = slot;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(req, 32'(cmd_done), 32'd1, "done pulse");
        check(req, 32'(cmd_status), 32'(st), "status");
    endtask

    // Combinational lookup check between clock edges.
    task automatic look(input logic [31:0] va, input logic fetch, input logic hit,
                        input logic [31:0] pa, input logic [23:0] req);
        lk_valid = 1'b1; lk_va = va; lk_fetch = fetch;
        #1;
        check(req, 32'(lk_hit), 32'(hit), "hit");
        if (hit) check(req, lk_pa, pa, "pa");
        else if (fetch) check(req, 32'(lk_imiss), 32'd1, "instruction miss");
        else check(req, 32'(lk_dmiss), 32'd1, "data miss");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL R12 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        // Reset state: empty buffer, no completion, miss kinds (R2, R12).
        do_reset();
        #1;
        check("R12", 32'(cmd_done), 32'd0, "done after reset");
        look(32'h0000_1000, 1'b1, 1'b0, 32'h0, "R2 ");
        check("R2 ", 32'(lk_dmiss), 32'd0, "no data miss on fetch");
        look(32'h0000_1000, 1'b0, 1'b0, 32'h0, "R2 ");
        lk_valid = 1'b0; #1;
        check("R2 ", 32'({lk_hit, lk_imiss, lk_dmiss}), 32'd0, "idle lookup silent");

        // Vector table.
        for (int v = 0; v < NV; v++) begin
            do_cmd(VEC[v].op, VEC[v].va, VEC[v].pa, VEC[v].arg, 29'h0, VEC[v].slot, VEC[v].st, VEC[v].tag);
            look(VEC[v].lva, VEC[v].lf, VEC[v].lhit, VEC[v].lpa, VEC[v].tag);
        end

        // R10: protection word layout round trip.
        do_reset();
        do_cmd(OP_VAR, 32'h00A0_0000, 32'h00B0_0000, 32'd0, 29'(32'h156D_5554 >> 1), 3'd0, S_OK, "R10");
        look(32'h00A0_0004, 1'b0, 1'b1, 32'h00B0_0004, "R10");
        check("R10", {2'b00, lk_prot, 1'b0}, 32'h156D_5554, "prot word");
        check("R10", 32'(lk_prot[26:24]), 32'd5, "type field");

        // R4: insert removes overlapping ordinary entry.
        do_cmd(OP_VAR, 32'h0070_0000, 32'h0100_0000, 32'd1, 29'h0, 3'd0, S_OK, "R4 ");
        do_cmd(OP_VAR, 32'h0070_2000, 32'h0200_0000, 32'd0, 29'h0, 3'd0, S_OK, "R4 ");
        look(32'h0070_0000, 1'b0, 1'b0, 32'h0, "R4 ");
        look(32'h0070_2010, 1'b0, 1'b1, 32'h0200_0010, "R4 ");
        // R6/R1: block entry kept against an overlapping insert, lowest slot wins.
        do_cmd(OP_BINS, 32'h0090_0000, 32'h0300_0000, 32'd1, 29'h0, 3'd0, S_OK, "R6 ");
        do_cmd(OP_VAR, 32'h0090_0000, 32'h0400_0000, 32'd0, 29'h0, 3'd0, S_OK, "R6 ");
        look(32'h0090_0004, 1'b0, 1'b1, 32'h0300_0004, "R1 ");
        do_cmd(OP_BPALL, 32'h0, 32'h0, 32'd0, 29'h0, 3'd0, S_OK, "R11");
        look(32'h0090_0004, 1'b0, 1'b1, 32'h0400_0004, "R11");

        // R8: purge-all keeps blocks and cancels the pending insert.
        do_cmd(OP_BINS, 32'h0C00_0000, 32'h0D00_0000, 32'd2, 29'h0, 3'd1, S_OK, "R8 ");
        do_cmd(OP_ADDR, 32'h0E00_0000, 32'h0F00_0000, 32'd0, 29'h0, 3'd0, S_OK, "R8 ");
        do_cmd(OP_PALL, 32'h0, 32'h0, 32'd0, 29'h0, 3'd0, S_OK, "R8 ");
        look(32'h0C00_1000, 1'b0, 1'b1, 32'h0D00_1000, "R8 ");
        look(32'h0070_2010, 1'b0, 1'b0, 32'h0, "R8 ");
        do_cmd(OP_PROT, 32'h0E00_0000, 32'h0, 32'd0, 29'h0, 3'd0, S_SEQ, "R8 ");

        // R7: free slots first, then round-robin with wrap.
        do_reset();
        for (int i = 0; i < 6; i++)
            do_cmd(OP_VAR, 32'h0100_0000 + 32'(i) * 32'h1000, 32'h0800_0000 + 32'(i) * 32'h1000,
                   32'd0, 29'h0, 3'd0, S_OK, "R7 ");
        do_cmd(OP_VAR, 32'h0100_6000, 32'h0800_6000, 32'd0, 29'h0, 3'd0, S_OK, "R7 ");
        look(32'h0100_0000, 1'b0, 1'b0, 32'h0, "R7 ");
        look(32'h0100_6008, 1'b0, 1'b1, 32'h0800_6008, "R7 ");
        do_cmd(OP_VAR, 32'h0100_7000, 32'h0800_7000, 32'd0, 29'h0, 3'd0, S_OK, "R7 ");
        do_cmd(OP_PURGE, 32'h0100_3000, 32'h0, 32'd0, 29'h0, 3'd0, S_OK, "R7 ");
        do_cmd(OP_VAR, 32'h0100_8000, 32'h0800_8000, 32'd0, 29'h0, 3'd0, S_OK, "R7 ");
        look(32'h0100_8000, 1'b0, 1'b1, 32'h0800_8000, "R7 ");
        do_cmd(OP_VAR, 32'h0100_9000, 32'h0800_9000, 32'd0, 29'h0, 3'd0, S_OK, "R7 ");
        look(32'h0100_2000, 1'b0, 1'b0, 32'h0, "R7 ");
        look(32'h0100_4000, 1'b0, 1'b1, 32'h0800_4000, "R7 ");
        for (int i = 10; i < 14; i++)
            do_cmd(OP_VAR, 32'h0100_0000 + 32'(i) * 32'h1000, 32'h0800_0000 + 32'(i) * 32'h1000,
                   32'd0, 29'h0, 3'd0, S_OK, "R7 ");
        look(32'h0100_6000, 1'b0, 1'b0, 32'h0, "R7 ");
        look(32'h0100_8000, 1'b0, 1'b0, 32'h0, "R7 ");
        look(32'h0100_7000, 1'b0, 1'b1, 32'h0800_7000, "R7 ");
        look(32'h0100_C000, 1'b1, 1'b1, 32'h0800_C000, "R7 ");

        // R12: lookup in the purge cycle sees the pre-purge state.
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = OP_PURGE; cmd_va = 32'h0100_7000;
        lk_valid = 1'b1; lk_fetch = 1'b0; lk_va = 32'h0100_7000;
        #1;
        check("R12", 32'(lk_hit), 32'd1, "same-cycle lookup before purge");
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R12", 32'(cmd_done), 32'd1, "purge done");
        look(32'h0100_7000, 1'b0, 1'b0, 32'h0, "R12");

        finish_run();
    end
endmodule